// File: doc/BRIEF.md
# Color Window Bounding Box Tracker

The block watches a raster stream of RGB pixels and picks out those whose color lies inside a programmable box in RGB space. Each color channel has its own inclusive lower and upper limit. The stream runs from the top-left pixel, left to right along a line, and then down line by line. While the frame streams, the block keeps running statistics on the matching pixels: the smallest rectangle that encloses them, how many there are, and the sums of their column and row positions. When the frame closes, it reports the rectangle, the count and the centroid, which is the mean column and mean row.

An optional noise filter removes isolated hits. With the filter on, a pixel is accepted only when it matches and its left neighbour and the pixel above it also match. The match bits of the previous line are held in a one-bit-per-column line buffer. The centroid is produced by a shared-latency restoring divider. A frame with no accepted pixel skips the divide and is flagged right away.

Top module: `color_box_tracker`

## Requirements
- R1: A pixel is in the window only when each of R, G and B is greater than or equal to its low limit and less than or equal to its high limit. Both limits are inclusive. A channel whose low limit is above its high limit lets no pixel match.
- R2: Columns count accepted `pix_valid` cycles from 0 at the pixel that carries `pix_sof`. After a pixel with `pix_eol`, the column restarts at 0 and the row advances by 1. Rows start at 0 on the `pix_sof` pixel. Idle cycles with `pix_valid` low move neither counter.
- R3: With targets present, `res_top`/`res_bottom` are the smallest and largest row of the accepted pixels, and `res_left`/`res_right` are the smallest and largest column.
- R4: `res_count` equals the number of accepted pixels in the frame.
- R5: `res_cx` and `res_cy` are the floor of the column sum and of the row sum divided by `res_count`. Each lies inside the reported box.
- R6: When a frame has no accepted pixel, `res_none` is 1, and the box, count and centroid are all 0. `res_valid` is high in the cycle after the edge that samples `frame_end`.
- R7: When a frame has accepted pixels, `res_valid` goes high after the 26th rising edge, counting the edge that samples `frame_end` as the first. `res_none` is then 0.
- R8: A `pix_sof` pixel discards all statistics of the earlier frame. Only pixels from that pixel onward contribute.
- R9: With `filt_en` high, a pixel is accepted only when it, its left neighbour on the same line and the pixel directly above it are all in the window. No pixel in column 0 or row 0 is accepted. With `filt_en` low, every in-window pixel is accepted.
- R10: `res_valid` is a single-cycle pulse. All result outputs keep their values until the next result is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| pix_valid | input | 1 | A pixel is present this cycle |
| pix_r | input | 8 | Red value |
| pix_g | input | 8 | Green value |
| pix_b | input | 8 | Blue value |
| pix_sof | input | 1 | Pixel is the first of a frame |
| pix_eol | input | 1 | Pixel is the last of its line |
| frame_end | input | 1 | Frame closed (cycle without a pixel) |
| filt_en | input | 1 | Enable the neighbour noise filter |
| r_lo | input | 8 | Red low limit |
| r_hi | input | 8 | Red high limit |
| g_lo | input | 8 | Green low limit |
| g_hi | input | 8 | Green high limit |
| b_lo | input | 8 | Blue low limit |
| b_hi | input | 8 | Blue high limit |
| res_valid | output | 1 | Result pulse |
| res_none | output | 1 | No accepted pixel in frame |
| res_top | output | 8 | Smallest row of accepted pixels |
| res_bottom | output | 8 | Largest row |
| res_left | output | 8 | Smallest column |
| res_right | output | 8 | Largest column |
| res_count | output | 17 | Accepted pixel count |
| res_cx | output | 8 | Centroid column |
| res_cy | output | 8 | Centroid row |

## Verification
The assertions take several things for granted about the inputs. `frame_end` arrives in a cycle without a pixel. Consecutive frame ends are more than 26 cycles apart, so the divider is never restarted while busy. Every line of a frame has the same length, so the line buffer always holds the line directly above. `filt_en` and the limits stay steady within a frame.

The bench builds frames of at most 16 by 12 pixels. It sets the limits and the filter mode before each frame, and it inserts random idle cycles only between pixels. After each frame end it waits for the result and a few more cycles before it starts the next frame.

// File: rtl/cbt_pkg.sv
package cbt_pkg;
    localparam int CW   = 8;
    localparam int XW   = 8;
    localparam int YW   = 8;
    localparam int CNTW = XW + YW + 1;
    localparam int SW   = ((XW > YW) ? XW : YW) + XW + YW;

    typedef struct packed {
        logic [CW-1:0] r;
        logic [CW-1:0] g;
        logic [CW-1:0] b;
    } rgb_t;

    typedef struct packed {
        rgb_t lo;
        rgb_t hi;
    } window_t;

    typedef struct packed {
        logic [YW-1:0] top;
        logic [YW-1:0] bottom;
        logic [XW-1:0] left;
        logic [XW-1:0] right;
    } box_t;

    typedef struct packed {
        logic [CNTW-1:0] cnt;
        logic [SW-1:0]   sx;
        logic [SW-1:0]   sy;
        box_t            box;
    } stats_t;

    function automatic logic chan_in(logic [CW-1:0] v, logic [CW-1:0] lo, logic [CW-1:0] hi);
        return (v >= lo) && (v <= hi);
    endfunction

    function automatic logic rgb_in(rgb_t p, window_t w);
        return chan_in(p.r, w.lo.r, w.hi.r) &&
               chan_in(p.g, w.lo.g, w.hi.g) &&
               chan_in(p.b, w.lo.b, w.hi.b);
    endfunction

    function automatic box_t box_point(logic [XW-1:0] x, logic [YW-1:0] y);
        box_t b;
        b.top = y; b.bottom = y; b.left = x; b.right = x;
        return b;
    endfunction

    function automatic box_t box_grow(box_t b, logic [XW-1:0] x, logic [YW-1:0] y);
        box_t n;
        n = b;
        if (y < b.top)    n.top    = y;
        if (y > b.bottom) n.bottom = y;
        if (x < b.left)   n.left   = x;
        if (x > b.right)  n.right  = x;
        return n;
    endfunction
endpackage

// File: rtl/cbt_window_match.sv
module cbt_window_match
    import cbt_pkg::*;
(
    input  rgb_t    pix,
    input  window_t win,
    output logic    hit
);
    always_comb hit = rgb_in(pix, win);
endmodule

// File: rtl/cbt_noise_filter.sv
module cbt_noise_filter
    import cbt_pkg::*;
#(
    parameter int DEPTH = 1 << XW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          pv,
    input  logic [XW-1:0] x,
    input  logic [YW-1:0] y,
    input  logic          raw,
    input  logic          filt_en,
    output logic          keep
);
    logic             above_bits [DEPTH];
    logic             left_q;
    logic             left_ok;
    logic             up_ok;

    always_comb begin
        left_ok = (x != '0) && left_q;
        up_ok   = (y != '0) && above_bits[x];
        keep    = filt_en ? (raw && left_ok && up_ok) : raw;
    end

    always_ff @(posedge clk) begin
        if (rst) left_q <= 1'b0;
        else if (pv) left_q <= raw;
    end

    always_ff @(posedge clk) begin
        if (pv) above_bits[x] <= raw;
    end

    // R9
    keep_implies_raw_chk: assert property (@(posedge clk) disable iff (rst)
        (pv && keep) |-> raw);

    // R9
    edge_pixel_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (pv && filt_en && (x == '0 || y == '0)) |-> !keep);
endmodule

// File: rtl/cbt_stats_accum.sv
module cbt_stats_accum
    import cbt_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          pv,
    input  logic          sof,
    input  logic [XW-1:0] x,
    input  logic [YW-1:0] y,
    input  logic          keep,
    output stats_t        st
);
    stats_t base;
    stats_t nxt;

    always_comb begin
        base = sof ? stats_t'('0) : st;
        nxt  = base;
        if (keep) begin
            nxt.cnt = base.cnt + 1'b1;
            nxt.sx  = base.sx + SW'(x);
            nxt.sy  = base.sy + SW'(y);
            nxt.box = (base.cnt == '0) ? box_point(x, y) : box_grow(base.box, x, y);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st <= '0;
        else if (pv) st <= nxt;
    end

    // R3
    box_ordered_chk: assert property (@(posedge clk) disable iff (rst)
        (st.cnt != '0) |-> (st.box.top <= st.box.bottom && st.box.left <= st.box.right));

    // R4
    count_monotone_chk: assert property (@(posedge clk) disable iff (rst)
        (pv && !sof) |=> (st.cnt >= $past(st.cnt)));

    // R8
    sof_restart_chk: assert property (@(posedge clk) disable iff (rst)
        (pv && sof) |=> (st.cnt <= 1));
endmodule

// File: rtl/cbt_divider.sv
module cbt_divider #(
    parameter int DW = 24,
    parameter int VW = 17,
    parameter int QW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [DW-1:0] dividend,
    input  logic [VW-1:0] divisor,
    output logic [QW-1:0] quo_out,
    output logic          done
);
    localparam int STW = $clog2(DW + 1);

    logic [DW-1:0]  quo;
    logic [VW-1:0]  rem;
    logic [VW-1:0]  dvs;
    logic [STW-1:0] step;
    logic           busy;
    logic [VW:0]    trial;
    logic           ge;

    always_comb begin
        trial = {rem, quo[DW-1]};
        ge    = trial >= {1'b0, dvs};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            quo <= '0; rem <= '0; dvs <= '0; step <= '0; busy <= 1'b0; done <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                busy <= 1'b1;
                step <= '0;
                rem  <= '0;
                quo  <= dividend;
                dvs  <= divisor;
            end else if (busy) begin
                rem  <= ge ? (trial[VW-1:0] - dvs) : trial[VW-1:0];
                quo  <= {quo[DW-2:0], ge};
                step <= step + 1'b1;
                if (step == STW'(DW - 1)) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end

    assign quo_out = quo[QW-1:0];

    // R7
    div_start_busy_chk: assert property (@(posedge clk) disable iff (rst)
        start |=> (busy && !done));

    // R10
    div_done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
endmodule

// File: rtl/color_box_tracker.sv
module color_box_tracker
    import cbt_pkg::*;
#(
    parameter int LB_DEPTH = 1 << XW
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            pix_valid,
    input  logic [CW-1:0]   pix_r,
    input  logic [CW-1:0]   pix_g,
    input  logic [CW-1:0]   pix_b,
    input  logic            pix_sof,
    input  logic            pix_eol,
    input  logic            frame_end,
    input  logic            filt_en,
    input  logic [CW-1:0]   r_lo,
    input  logic [CW-1:0]   r_hi,
    input  logic [CW-1:0]   g_lo,
    input  logic [CW-1:0]   g_hi,
    input  logic [CW-1:0]   b_lo,
    input  logic [CW-1:0]   b_hi,
    output logic            res_valid,
    output logic            res_none,
    output logic [YW-1:0]   res_top,
    output logic [YW-1:0]   res_bottom,
    output logic [XW-1:0]   res_left,
    output logic [XW-1:0]   res_right,
    output logic [CNTW-1:0] res_count,
    output logic [XW-1:0]   res_cx,
    output logic [YW-1:0]   res_cy
);
    rgb_t            pix;
    window_t         win;
    logic [XW-1:0]   x_q, px;
    logic [YW-1:0]   y_q, py;
    logic            raw_hit;
    logic            keep;
    stats_t          st;
    box_t            pend_box;
    logic [CNTW-1:0] pend_cnt;
    logic            div_start;
    logic            done_x, done_y;
    logic [XW-1:0]   qx;
    logic [YW-1:0]   qy;

    always_comb begin
        pix = '{r: pix_r, g: pix_g, b: pix_b};
        win.lo = '{r: r_lo, g: g_lo, b: b_lo};
        win.hi = '{r: r_hi, g: g_hi, b: b_hi};
        px = pix_sof ? '0 : x_q;
        py = pix_sof ? '0 : y_q;
        div_start = frame_end && (st.cnt != '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            x_q <= '0;
            y_q <= '0;
        end else if (pix_valid) begin
            if (pix_eol) begin
                x_q <= '0;
                y_q <= py + 1'b1;
            end else begin
                x_q <= px + 1'b1;
                y_q <= py;
            end
        end
    end

    cbt_window_match u_match (.pix(pix), .win(win), .hit(raw_hit));

    cbt_noise_filter #(.DEPTH(LB_DEPTH)) u_filt (
        .clk(clk), .rst(rst), .pv(pix_valid), .x(px), .y(py),
        .raw(raw_hit), .filt_en(filt_en), .keep(keep)
    );

    cbt_stats_accum u_acc (
        .clk(clk), .rst(rst), .pv(pix_valid), .sof(pix_sof),
        .x(px), .y(py), .keep(keep), .st(st)
    );

    cbt_divider #(.DW(SW), .VW(CNTW), .QW(XW)) u_div_x (
        .clk(clk), .rst(rst), .start(div_start), .dividend(st.sx),
        .divisor(st.cnt), .quo_out(qx), .done(done_x)
    );

    cbt_divider #(.DW(SW), .VW(CNTW), .QW(YW)) u_div_y (
        .clk(clk), .rst(rst), .start(div_start), .dividend(st.sy),
        .divisor(st.cnt), .quo_out(qy), .done(done_y)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_box <= '0;
            pend_cnt <= '0;
        end else if (div_start) begin
            pend_box <= st.box;
            pend_cnt <= st.cnt;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid <= 1'b0; res_none <= 1'b0;
            res_top <= '0; res_bottom <= '0; res_left <= '0; res_right <= '0;
            res_count <= '0; res_cx <= '0; res_cy <= '0;
        end else begin
            res_valid <= 1'b0;
            if (frame_end && st.cnt == '0) begin
                res_valid <= 1'b1; res_none <= 1'b1;
                res_top <= '0; res_bottom <= '0; res_left <= '0; res_right <= '0;
                res_count <= '0; res_cx <= '0; res_cy <= '0;
            end else if (done_x && done_y) begin
                res_valid  <= 1'b1;
                res_none   <= 1'b0;
                res_top    <= pend_box.top;
                res_bottom <= pend_box.bottom;
                res_left   <= pend_box.left;
                res_right  <= pend_box.right;
                res_count  <= pend_cnt;
                res_cx     <= qx;
                res_cy     <= qy;
            end
        end
    end

    // R10
    result_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        res_valid |=> !res_valid);

    // R6
    empty_frame_chk: assert property (@(posedge clk) disable iff (rst)
        (res_valid && res_none) |-> (res_count == '0 && res_cx == '0 && res_cy == '0));

    // R5
    centroid_in_box_chk: assert property (@(posedge clk) disable iff (rst)
        (res_valid && !res_none) |->
        (res_cx >= res_left && res_cx <= res_right && res_cy >= res_top && res_cy <= res_bottom));

    // R10
    result_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!res_valid && !$past(res_valid)) |-> ($stable(res_count) && $stable(res_cx)));

    // R6
    divider_pair_chk: assert property (@(posedge clk) disable iff (rst)
        done_x |-> done_y);
endmodule

// File: tb/sim_color_box_tracker.sv
module sim_color_box_tracker;
    localparam int DIV_LAT = 26;
    localparam int MAXW = 16;
    localparam int MAXH = 12;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pv = 1'b0, sof = 1'b0, eol = 1'b0, eof = 1'b0, filt = 1'b0;
    logic [7:0] pr = '0, pg = '0, pb = '0;
    logic [7:0] rlo = '0, rhi = '0, glo = '0, ghi = '0, blo = '0, bhi = '0;
    logic        rv, rn;
    logic [7:0]  rtop, rbot, rleft, rright, rcx, rcy;
    logic [16:0] rcnt;

    int n_chk = 0;
    int n_fail = 0;
    int cycles = 0;

    logic [7:0] fr [MAXH][MAXW];
    logic [7:0] fg [MAXH][MAXW];
    logic [7:0] fb [MAXH][MAXW];

    always #5 clk = ~clk;

    color_box_tracker u0 (
        .clk(clk), .rst(rst), .pix_valid(pv), .pix_r(pr), .pix_g(pg), .pix_b(pb),
        .pix_sof(sof), .pix_eol(eol), .frame_end(eof), .filt_en(filt),
        .r_lo(rlo), .r_hi(rhi), .g_lo(glo), .g_hi(ghi), .b_lo(blo), .b_hi(bhi),
        .res_valid(rv), .res_none(rn), .res_top(rtop), .res_bottom(rbot),
        .res_left(rleft), .res_right(rright), .res_count(rcnt), .res_cx(rcx), .res_cy(rcy)
    );

    task automatic chk(string req, string what, int got, int exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, got, exp);
        end
    endtask

    function automatic bit in_win(int y, int x);
        return fr[y][x] >= rlo && fr[y][x] <= rhi &&
               fg[y][x] >= glo && fg[y][x] <= ghi &&
               fb[y][x] >= blo && fb[y][x] <= bhi;
    endfunction

    function automatic bit accepted(int y, int x, bit f);
        if (!f) return in_win(y, x);
        if (x == 0 || y == 0) return 1'b0;
        return in_win(y, x) && in_win(y, x - 1) && in_win(y - 1, x);
    endfunction

    task automatic set_win(int a, int b, int c, int d, int e, int g);
        rlo = 8'(a); rhi = 8'(b); glo = 8'(c); ghi = 8'(d); blo = 8'(e); bhi = 8'(g);
    endtask

    task automatic fill_bg();
        for (int y = 0; y < MAXH; y++)
            for (int x = 0; x < MAXW; x++) begin
                fr[y][x] = 8'd0; fg[y][x] = 8'd0; fb[y][x] = 8'd0;
            end
    endtask

    task automatic put(int y, int x, int r, int g, int b);
        fr[y][x] = 8'(r); fg[y][x] = 8'(g); fb[y][x] = 8'(b);
    endtask

    task automatic run_frame(int w, int h, bit f, bit gaps, string tag);
        int cnt = 0, sx = 0, sy = 0, top = 0, bot = 0, lft = 0, rgt = 0, lat;
        int s_cnt, s_cx, s_cy, s_top;
        bit seen;
        for (int y = 0; y < h; y++)
            for (int x = 0; x < w; x++)
                if (accepted(y, x, f)) begin
                    if (cnt == 0) begin top = y; bot = y; lft = x; rgt = x; end
                    else begin
                        if (y < top) top = y;
                        if (y > bot) bot = y;
                        if (x < lft) lft = x;
                        if (x > rgt) rgt = x;
                    end
                    cnt++; sx += x; sy += y;
                end
        filt = f;
        for (int y = 0; y < h; y++)
            for (int x = 0; x < w; x++) begin
                if (gaps && ($urandom % 4 == 0)) begin
                    @(negedge clk); pv = 1'b0; sof = 1'b0; eol = 1'b0;
                end
                @(negedge clk);
                pv = 1'b1; pr = fr[y][x]; pg = fg[y][x]; pb = fb[y][x];
                sof = (x == 0 && y == 0); eol = (x == w - 1);
            end
        @(negedge clk); pv = 1'b0; sof = 1'b0; eol = 1'b0; eof = 1'b1;
        @(negedge clk); eof = 1'b0;
        lat = 1; seen = rv;
        while (!seen && lat < 40) begin
            @(negedge clk); lat++; seen = rv;
        end
        if (cnt == 0) begin
            chk("R6", {tag, " latency"}, lat, 1);
            chk("R6", {tag, " none"}, int'(rn), 1);
            chk("R6", {tag, " box"}, int'(rtop) + int'(rbot) + int'(rleft) + int'(rright), 0);
            chk("R6", {tag, " centroid"}, int'(rcx) + int'(rcy) + int'(rcnt), 0);
        end else begin
            chk("R7", {tag, " latency"}, lat, DIV_LAT);
            chk("R7", {tag, " none"}, int'(rn), 0);
            chk("R3", {tag, " top"}, int'(rtop), top);
            chk("R3", {tag, " bottom"}, int'(rbot), bot);
            chk("R3", {tag, " left"}, int'(rleft), lft);
            chk("R3", {tag, " right"}, int'(rright), rgt);
            chk("R4", {tag, " count"}, int'(rcnt), cnt);
            chk("R5", {tag, " cx"}, int'(rcx), sx / cnt);
            chk("R5", {tag, " cy"}, int'(rcy), sy / cnt);
        end
        s_cnt = int'(rcnt); s_cx = int'(rcx); s_cy = int'(rcy); s_top = int'(rtop);
        @(negedge clk);
        chk("R10", {tag, " pulse"}, int'(rv), 0);
        @(negedge clk); @(negedge clk);
        chk("R10", {tag, " hold"}, int'(rcnt) + int'(rcx) + int'(rcy) + int'(rtop),
            s_cnt + s_cx + s_cy + s_top);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                n_chk++; n_fail++;
                $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
                finish_run();
            end
        end
    end

    initial begin
        void'($urandom(32'd4242));
        fill_bg();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R10", "reset valid", int'(rv), 0);
        chk("R6", "reset count", int'(rcnt), 0);

        // R6: empty frame
        set_win(100, 200, 100, 200, 100, 200);
        run_frame(8, 4, 1'b0, 1'b0, "empty");

        // R3 R5: single pixel at column 5 row 3
        put(3, 5, 150, 150, 150);
        run_frame(8, 6, 1'b0, 1'b1, "single");

        // R1: inclusive limits, low and high edges match
        fill_bg();
        put(0, 0, 100, 200, 100);
        put(1, 2, 200, 100, 200);
        put(1, 3, 99, 150, 150);
        put(1, 4, 150, 201, 150);
        run_frame(6, 3, 1'b0, 1'b0, "inclusive");

        // R1: low above high on green matches nothing
        set_win(0, 255, 200, 100, 0, 255);
        run_frame(6, 3, 1'b0, 1'b0, "inverted");

        // R9: isolated pixel dropped, 2x2 block leaves bottom-right pixel
        set_win(100, 200, 100, 200, 100, 200);
        fill_bg();
        put(1, 1, 150, 150, 150);
        put(3, 4, 150, 150, 150); put(3, 5, 150, 150, 150);
        put(4, 4, 150, 150, 150); put(4, 5, 150, 150, 150);
        run_frame(8, 6, 1'b1, 1'b0, "filter2x2");
        // R9: row 0 and column 0 never accepted in filter mode
        fill_bg();
        for (int x = 0; x < 8; x++) put(0, x, 150, 150, 150);
        for (int y = 0; y < 6; y++) put(y, 0, 150, 150, 150);
        run_frame(8, 6, 1'b1, 1'b0, "filteredge");
        // R8 R2: same data unfiltered, new frame restarts statistics
        run_frame(8, 6, 1'b0, 1'b1, "restart");

        for (int i = 0; i < 40; i++) begin
            int w, h, lo[3], hi[3];
            w = 3 + int'($urandom % 14);
            h = 2 + int'($urandom % 11);
            for (int c = 0; c < 3; c++) begin
                lo[c] = int'($urandom % 160);
                hi[c] = lo[c] + int'($urandom % 96);
            end
            set_win(lo[0], hi[0], lo[1], hi[1], lo[2], hi[2]);
            for (int y = 0; y < MAXH; y++)
                for (int x = 0; x < MAXW; x++)
                    if ($urandom % 3 != 0)
                        put(y, x, lo[0] + int'($urandom % (hi[0] - lo[0] + 1)),
                                  lo[1] + int'($urandom % (hi[1] - lo[1] + 1)),
                                  lo[2] + int'($urandom % (hi[2] - lo[2] + 1)));
                    else
                        put(y, x, int'($urandom % 256), int'($urandom % 256), int'($urandom % 256));
            run_frame(w, h, 1'($urandom % 2), 1'($urandom % 2), "random");
        end
        finish_run();
    end
endmodule